// File: doc/BRIEF.md
# Maintenance Interrupt Status Controller

This block collects the event pulses of a serial-link maintenance unit and turns them into one level-sensitive interrupt. Five event sources are latched into sticky status bits: an inbound port-write error, an inbound port-write that was dropped, an inbound port-write that was stored, and an outbound maintenance read or write whose address missed every enabled translation window. The window hit or miss is computed elsewhere and arrives as a flag beside the request pulse. A companion enable register selects which status bits may raise the interrupt. Software reaches both registers through a simple 32-bit read/write port and clears status by writing ones.

The block also owns a one-entry buffer for inbound port-write payloads. Each payload arrives on a valid/ready stream. `pw_ready` is held high, so a beat is taken in every cycle that `pw_valid` is high and the stream never applies back-pressure. The block stores or drops each beat itself. A beat is dropped when reception is switched off or the buffer still holds an unread payload. Software frees the buffer by reading the payload register. Flow control is therefore the sender's job: it must watch the drop status, because the ready line never tells it anything.

Top module: `mnt_irq_ctrl`

## Requirements
- R1: After reset the status register, enable register and `irq` are all 0, and the payload buffer is empty.
- R2: The status register is at offset 0x10080 and the enable register at 0x10084. In both, bits [31:7] and [3:2] always read 0 and writes to them have no effect.
- R3: Each event sets its status bit, and the bit stays set until software clears it. The bit positions are: bit 6 port-write error, bit 5 port-write dropped, bit 4 port-write stored, bit 1 write out of bounds, bit 0 read out of bounds.
- R4: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R5: The enable bits (positions 6, 5, 4, 1, 0) are plain read/write.
- R6: `irq` is registered. It goes high one clock after some status bit and its enable bit are both 1, and goes low one clock after no such pair remains.
- R7: A port-write beat that arrives while `pw_rx_en` is 0 is dropped. It sets bit 5 and leaves the buffer unchanged.
- R8: A port-write beat that arrives while the buffer holds an unread payload is dropped. It sets bit 5, and the payload already held is kept.
- R9: An accepted beat sets bit 4 and fills the buffer. Reading offset 0x10088 returns the payload and frees the buffer.
- R10: If the payload is read in the same cycle that a new beat arrives with reception on, the buffer is freed first, so the new beat is accepted and no drop is flagged.
- R11: If an event and a software clear hit the same status bit in the same cycle, the bit stays set.
- R12: A maintenance read or write request sets bit 0 or bit 1 only when `win_hit` is 0 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a read of the payload register frees the buffer) |
| reg_addr | input | 20 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid in the strobe cycle |
| pw_valid | input | 1 | Inbound port-write payload beat valid |
| pw_ready | output | 1 | Always 1; every beat is taken, then stored or dropped |
| pw_data | input | 32 | Inbound port-write payload |
| pw_rx_en | input | 1 | Port-write reception enable |
| pw_err | input | 1 | Port-write error event pulse |
| mnt_rd_req | input | 1 | Outbound maintenance read request pulse |
| mnt_wr_req | input | 1 | Outbound maintenance write request pulse |
| win_hit | input | 1 | Request address hit an enabled window |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume that every event input is a single-cycle pulse, sampled once at a clock edge. They also assume that `win_hit` only matters in a cycle where a read or write request is high, and that a register strobe lasts exactly one cycle, so one payload read frees the buffer exactly once. The stimulus drives every event and strobe for exactly one clock, changes inputs only on the falling edge, and returns them to 0 afterwards. Clears and payload reads happen in quiet cycles, except in the tests that deliberately collide them with an event.

// File: rtl/mic_pkg.sv
package mic_pkg;
  localparam int NBITS = 7;

  // Status and enable bit positions.
  localparam int B_RD_OOB = 0;
  localparam int B_WR_OOB = 1;
  localparam int B_STORED = 4;
  localparam int B_DROP   = 5;
  localparam int B_PW_ERR = 6;

  localparam logic [NBITS-1:0] IMPL_MASK = 7'b111_0011;

  // Register byte offsets.
  localparam int OFS_STATUS  = 'h10080;
  localparam int OFS_ENABLE  = 'h10084;
  localparam int OFS_PAYLOAD = 'h10088;

  typedef logic [NBITS-1:0] evbits_t;
endpackage

// File: rtl/mic_sticky_bits.sv
module mic_sticky_bits
  import mic_pkg::*;
#(
  parameter int W = NBITS,
  parameter logic [W-1:0] MASK = IMPL_MASK
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] sts_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (MASK[i]) begin : g_impl
      logic q;
      always_ff @(posedge clk) begin
        if (!rst_n)        q <= 1'b0;
        else if (set_i[i]) q <= 1'b1;
        else if (clr_i[i]) q <= 1'b0;
      end
      assign sts_o[i] = q;

      // R3
      sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i[i] |=> sts_o[i]);
      // R11
      set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i[i] && clr_i[i]) |=> sts_o[i]);
      // R4
      w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i[i] && !set_i[i]) |=> !sts_o[i]);
      // R4
      hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i[i] && !set_i[i] && sts_o[i]) |=> sts_o[i]);
    end else begin : g_rsvd
      assign sts_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/mic_pw_slot.sv
module mic_pw_slot #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              rx_en,
  input  logic              take_i,
  output logic [DATA_W-1:0] data_o,
  output logic              stored_o,
  output logic              dropped_o
);
  logic              full_q;
  logic [DATA_W-1:0] data_q;
  logic              room;
  logic              accept;

  // A read in this cycle empties the slot before the new beat is judged.
  assign room      = !full_q || take_i;
  assign accept    = in_valid && rx_en && room;
  assign stored_o  = accept;
  assign dropped_o = in_valid && !accept;
  assign data_o    = data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      if (accept)      full_q <= 1'b1;
      else if (take_i) full_q <= 1'b0;
      if (accept) data_q <= in_data;
    end
  end

  // R7
  rx_off_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !rx_en) |-> (dropped_o && !stored_o));
  // R8
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && full_q && !take_i) |-> !stored_o);
  // R8
  keep_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !take_i) |=> $stable(data_q));
  // R10
  same_cycle_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && rx_en && take_i) |-> (stored_o && !dropped_o));
  // R9
  fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stored_o |=> full_q);
endmodule

// File: rtl/mnt_irq_ctrl.sv
module mnt_irq_ctrl
  import mic_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int REG_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              pw_valid,
  output logic              pw_ready,
  input  logic [REG_W-1:0]  pw_data,
  input  logic              pw_rx_en,
  input  logic              pw_err,
  input  logic              mnt_rd_req,
  input  logic              mnt_wr_req,
  input  logic              win_hit,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(OFS_STATUS);
  localparam logic [ADDR_W-1:0] A_EN  = ADDR_W'(OFS_ENABLE);
  localparam logic [ADDR_W-1:0] A_PL  = ADDR_W'(OFS_PAYLOAD);

  logic       hit_sts, hit_en, hit_pl;
  evbits_t    set_v, clr_v, sts, en_q;
  logic       pw_stored, pw_dropped;
  logic [REG_W-1:0] pl_data;
  logic       unused_wdata_hi;

  assign hit_sts = (reg_addr == A_STS);
  assign hit_en  = (reg_addr == A_EN);
  assign hit_pl  = (reg_addr == A_PL);
  assign unused_wdata_hi = ^reg_wdata[REG_W-1:NBITS];

  assign pw_ready = 1'b1;

  mic_pw_slot #(.DATA_W(REG_W)) u_slot (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (pw_valid),
    .in_data   (pw_data),
    .rx_en     (pw_rx_en),
    .take_i    (reg_rd && hit_pl),
    .data_o    (pl_data),
    .stored_o  (pw_stored),
    .dropped_o (pw_dropped)
  );

  always_comb begin
    set_v           = '0;
    set_v[B_PW_ERR] = pw_err;
    set_v[B_DROP]   = pw_dropped;
    set_v[B_STORED] = pw_stored;
    set_v[B_WR_OOB] = mnt_wr_req && !win_hit;
    set_v[B_RD_OOB] = mnt_rd_req && !win_hit;
  end

  assign clr_v = (reg_wr && hit_sts) ? (reg_wdata[NBITS-1:0] & IMPL_MASK) : '0;

  mic_sticky_bits #(.W(NBITS), .MASK(IMPL_MASK)) u_sts (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (set_v),
    .clr_i (clr_v),
    .sts_o (sts)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= '0;
      irq  <= 1'b0;
    end else begin
      if (reg_wr && hit_en) en_q <= reg_wdata[NBITS-1:0] & IMPL_MASK;
      irq <= |(sts & en_q);
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      if (hit_sts)     reg_rdata[NBITS-1:0] = sts;
      else if (hit_en) reg_rdata[NBITS-1:0] = en_q;
      else if (hit_pl) reg_rdata            = pl_data;
    end
  end

  // R6
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(sts & en_q)) |=> irq);
  // R6
  irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(sts & en_q)) |=> !irq);
  // R2
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && (hit_sts || hit_en)) |-> (reg_rdata[REG_W-1:NBITS] == '0 && reg_rdata[3:2] == 2'b00));
  // R12
  oob_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mnt_rd_req && !win_hit) |=> sts[B_RD_OOB]);
  // R12
  oob_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mnt_wr_req && !win_hit) |=> sts[B_WR_OOB]);
endmodule

// File: tb/tb_mnt_irq_ctrl.sv
module tb_mnt_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 0, reg_rd = 0;
  logic [19:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        pw_valid = 0, pw_ready;
  logic [31:0] pw_data = '0;
  logic        pw_rx_en = 0, pw_err = 0, mnt_rd_req = 0, mnt_wr_req = 0, win_hit = 0;
  logic        irq;

  int total = 0, bad = 0;
  bit done = 0;

  localparam logic [19:0] A_STS = 20'h10080;
  localparam logic [19:0] A_EN  = 20'h10084;
  localparam logic [19:0] A_PL  = 20'h10088;

  always #2 clk = ~clk;

  mnt_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pw_valid(pw_valid), .pw_ready(pw_ready), .pw_data(pw_data),
    .pw_rx_en(pw_rx_en), .pw_err(pw_err), .mnt_rd_req(mnt_rd_req),
    .mnt_wr_req(mnt_wr_req), .win_hit(win_hit), .irq(irq)
  );

  // Vector: {pw_err, pw_valid, rd_req, wr_req, win_hit, rx_en} -> status
  localparam int NV = 8;
  localparam logic [12:0] VEC [NV] = '{
    {6'b100000, 7'h40},  // R3 bit 6
    {6'b010001, 7'h10},  // R9 bit 4
    {6'b010000, 7'h20},  // R7 bit 5
    {6'b001000, 7'h01},  // R12 bit 0
    {6'b000100, 7'h02},  // R12 bit 1
    {6'b001010, 7'h00},  // R12 hit, no flag
    {6'b000110, 7'h00},  // R12 hit, no flag
    {6'b101100, 7'h43}   // R3 several at once
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [19:0] a, input logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    step();
    reg_wr = 0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [19:0] a, output logic [31:0] d);
    reg_rd = 1; reg_addr = a;
    #1 d = reg_rdata;
    step();
    reg_rd = 0;
  endtask

  task automatic pw_send(input logic [31:0] d);
    pw_valid = 1; pw_data = d;
    step();
    pw_valid = 0;
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) step();
    rst_n = 1;
    step();

    // R1 reset state
    rd(A_STS, v); chk("R1 status", v, 0);
    rd(A_EN, v);  chk("R1 enable", v, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    pw_rx_en = 1; pw_send(32'h1111_0001);
    rd(A_STS, v); chk("R1 empty slot accepts", v, 32'h10);
    rd(A_PL, v);  chk("R1 payload", v, 32'h1111_0001);
    wr(A_STS, 32'h7F);
    pw_rx_en = 0;

    // Vector table: R3 R7 R9 R12
    for (int i = 0; i < NV; i++) begin
      {pw_err, pw_valid, mnt_rd_req, mnt_wr_req, win_hit, pw_rx_en} = VEC[i][12:7];
      pw_data = 32'hA000_0000 + i;
      step();
      {pw_err, pw_valid, mnt_rd_req, mnt_wr_req, win_hit} = '0;
      rd(A_STS, v); chk($sformatf("R3 vector %0d", i), v, {25'b0, VEC[i][6:0]});
      wr(A_STS, 32'h7F);
      rd(A_PL, v);
      pw_rx_en = 0;
    end
    rd(A_STS, v); chk("R4 all cleared", v, 0);

    // R2 reserved bits
    wr(A_EN, 32'hFFFF_FFFF);
    rd(A_EN, v); chk("R2 enable reserved", v, 32'h73);
    // R5 enable read/write
    wr(A_EN, 32'h0000_0012);
    rd(A_EN, v); chk("R5 enable rw", v, 32'h12);
    wr(A_EN, 32'h0);

    // R4 write 0 leaves, write 1 clears
    pw_err = 1; mnt_rd_req = 1; step(); pw_err = 0; mnt_rd_req = 0;
    wr(A_STS, 32'hFFFF_FF80);
    rd(A_STS, v); chk("R4 zero write keeps", v, 32'h41);
    wr(A_STS, 32'h40);
    rd(A_STS, v); chk("R4 one clears", v, 32'h01);
    wr(A_STS, 32'h01);
    rd(A_STS, v); chk("R2 status reserved", v, 0);

    // R6 irq one cycle after status
    wr(A_EN, 32'h01);
    mnt_rd_req = 1; step(); mnt_rd_req = 0;
    chk("R6 irq not yet", {31'b0, irq}, 0);
    step();
    chk("R6 irq raised", {31'b0, irq}, 1);
    wr(A_STS, 32'h01);
    chk("R6 irq lags clear", {31'b0, irq}, 1);
    step();
    chk("R6 irq dropped", {31'b0, irq}, 0);
    // R6 enable off keeps irq low
    wr(A_EN, 32'h0);
    mnt_rd_req = 1; step(); mnt_rd_req = 0;
    step(); step();
    chk("R6 masked", {31'b0, irq}, 0);
    wr(A_STS, 32'h7F);

    // R11 set beats clear
    mnt_wr_req = 1; reg_wr = 1; reg_addr = A_STS; reg_wdata = 32'h02;
    step();
    mnt_wr_req = 0; reg_wr = 0; reg_wdata = 0;
    rd(A_STS, v); chk("R11 set wins", v, 32'h02);
    wr(A_STS, 32'h7F);

    // R8 drop when occupied
    pw_rx_en = 1;
    pw_send(32'hBEEF_0001);
    pw_send(32'hBEEF_0002);
    rd(A_STS, v); chk("R8 drop flagged", v, 32'h30);
    wr(A_STS, 32'h7F);

    // R10 read and arrival together
    reg_rd = 1; reg_addr = A_PL; pw_valid = 1; pw_data = 32'hCAFE_0003;
    #1 v = reg_rdata;
    chk("R8 old payload kept", v, 32'hBEEF_0001);
    step();
    reg_rd = 0; pw_valid = 0;
    rd(A_STS, v); chk("R10 stored no drop", v, 32'h10);
    rd(A_PL, v);  chk("R10 new payload", v, 32'hCAFE_0003);
    wr(A_STS, 32'h7F);
    // R9 read freed the slot
    pw_send(32'hD00D_0004);
    rd(A_STS, v); chk("R9 slot freed", v, 32'h10);
    rd(A_PL, v);  chk("R9 payload", v, 32'hD00D_0004);

    // R7 rx disabled leaves buffer empty
    wr(A_STS, 32'h7F);
    pw_rx_en = 0;
    pw_send(32'hEEEE_0005);
    pw_rx_en = 1;
    pw_send(32'hEEEE_0006);
    rd(A_STS, v); chk("R7 drop then store", v, 32'h30);
    rd(A_PL, v);  chk("R7 buffer untouched", v, 32'hEEEE_0006);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule